// File: doc/BRIEF.md
# Transmit Jabber Watchdog

This block guards the transmit path of a 10/100 Ethernet port against a station that keeps transmit enable asserted for too long. At 10 Mbps it counts the consecutive clock cycles in which transmit enable is high. When a burst goes beyond a programmable cycle limit, the block enters a jabber state. In that state it drives a force-idle signal to the line driver, asserts collision toward the MAC, and raises a per-channel jabber flag. The same event sets a sticky status bit.

The jabber state is held until transmit enable has been low for an unbroken quiet period. That period is a parameter, 0.5 s by default, counted in clock cycles. Detection is inactive at 100 Mbps and when the global disable input is set. Either condition also ends a jabber state that is already in progress. The sticky status bit is cleared by a read strobe that arrives while no jabber is active. For a 20 ms limit with a 50 MHz clock, software programs the limit to 1,000,000.

Top module: `jab_wdog`

## Requirements
- R1: After reset, `tx_force_idle`, `mac_col`, `chan_jab` and `stat_jab` are all 0.
- R2: At 10 Mbps with detection enabled, a burst of exactly `limit` consecutive high samples of `tx_en` does not trip. The edge that samples the (`limit`+1)-th consecutive high trips the watchdog, and the outputs are high right after that edge.
- R3: While jabber is active, `tx_force_idle`, `mac_col` and `chan_jab` are all 1, and they stay 1 while `tx_en` stays high.
- R4: With `speed_100`=1 no burst length trips. A clock edge that samples `speed_100`=1 during jabber ends the jabber state at that edge.
- R5: With `jab_dis`=1 no burst length trips. A clock edge that samples `jab_dis`=1 during jabber ends the jabber state at that edge.
- R6: A single low sample of `tx_en` restarts the burst count, so two bursts of `limit` cycles separated by one low cycle do not trip.
- R7: Jabber ends at the edge that samples the `UNJAB_CYC`-th consecutive low of `tx_en`. A high sample during the quiet period restarts the quiet count.
- R8: `stat_jab` is set at the trip edge, even if `rd_stb` is high at that edge. It stays 1 after jabber ends. It clears at an edge where `rd_stb`=1 and jabber is not active. An `rd_stb` during jabber leaves it at 1.
- R9: The limit is taken from the `limit` input, so with `limit`=2 a burst of 3 cycles trips.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit enable from the MAC |
| speed_100 | input | 1 | 1 = 100 Mbps mode, 0 = 10 Mbps mode |
| jab_dis | input | 1 | Global jabber detection disable |
| limit | input | LIM_W | Maximum burst length in clock cycles |
| rd_stb | input | 1 | Status read strobe, clears the sticky bit |
| tx_force_idle | output | 1 | Forces the transmit line to idle |
| mac_col | output | 1 | Collision indication toward the MAC |
| chan_jab | output | 1 | Live per-channel jabber flag |
| stat_jab | output | 1 | Sticky jabber status bit |

## Verification
The bench places bursts at exactly the limit and one cycle past it. A counter that is off by one would trip early or late by a cycle. It also splits a burst with a single low cycle; a design that did not restart its count would trip there. The quiet period is broken by one high cycle, so a design that keeps counting instead of restarting would release early. The bench also checks a read strobe at the trip edge and during jabber, and a switch to 100 Mbps or to disable in mid-jabber. A wrong set/clear priority or missing gating would leave the status or the force-idle output wrong.

// File: rtl/jab_pkg.sv
`timescale 1ns/1ps
package jab_pkg;
  typedef enum logic {JAB_OFF = 1'b0, JAB_ON = 1'b1} jab_st_t;

  function automatic int unsigned ms_to_cyc(input int unsigned clk_hz,
                                            input int unsigned ms);
    return (clk_hz / 1000) * ms;
  endfunction
endpackage

// File: rtl/jab_burst_timer.sv
`timescale 1ns/1ps
module jab_burst_timer #(
  parameter int LIM_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             tx_en,
  input  logic [LIM_W-1:0] limit,
  output logic             over
);
  localparam int CW = LIM_W + 1;
  logic [CW-1:0] run_cnt;

  // run_cnt holds the number of earlier consecutive high samples
  assign over = tx_en && (run_cnt >= {1'b0, limit});

  always_ff @(posedge clk) begin
    if (rst || clr || !tx_en) begin
      run_cnt <= '0;
    end else if (run_cnt != {CW{1'b1}}) begin
      run_cnt <= run_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/jab_quiet_timer.sv
`timescale 1ns/1ps
module jab_quiet_timer #(
  parameter int UNJAB_CYC = 25_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tx_en,
  output logic done
);
  localparam int QW = (UNJAB_CYC > 1) ? $clog2(UNJAB_CYC) : 1;
  localparam logic [QW-1:0] LAST = QW'(UNJAB_CYC - 1);
  logic [QW-1:0] quiet;

  assign done = run && !tx_en && (quiet == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run || tx_en || done) begin
      quiet <= '0;
    end else begin
      quiet <= quiet + 1'b1;
    end
  end
endmodule

// File: rtl/jab_status.sv
`timescale 1ns/1ps
module jab_status (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic jab_live,
  input  logic rd_stb,
  output logic sticky
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sticky <= 1'b0;
    end else if (set) begin
      sticky <= 1'b1;
    end else if (rd_stb && !jab_live) begin
      sticky <= 1'b0;
    end
  end
endmodule

// File: rtl/jab_wdog.sv
`timescale 1ns/1ps
module jab_wdog
  import jab_pkg::*;
#(
  parameter int CLK_HZ    = 50_000_000,
  parameter int UNJAB_MS  = 500,
  parameter int UNJAB_CYC = int'(ms_to_cyc(CLK_HZ, UNJAB_MS)),
  parameter int LIM_W     = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_en,
  input  logic             speed_100,
  input  logic             jab_dis,
  input  logic [LIM_W-1:0] limit,
  input  logic             rd_stb,
  output logic             tx_force_idle,
  output logic             mac_col,
  output logic             chan_jab,
  output logic             stat_jab
);
  jab_st_t st;
  logic    active;
  logic    over;
  logic    quiet_done;
  logic    trip;

  assign active = !speed_100 && !jab_dis;
  assign trip   = active && (st == JAB_OFF) && over;

  jab_burst_timer #(.LIM_W(LIM_W)) u_burst (
    .clk   (clk),
    .rst   (rst),
    .clr   (!active || (st == JAB_ON)),
    .tx_en (tx_en),
    .limit (limit),
    .over  (over)
  );

  jab_quiet_timer #(.UNJAB_CYC(UNJAB_CYC)) u_quiet (
    .clk   (clk),
    .rst   (rst),
    .run   (active && (st == JAB_ON)),
    .tx_en (tx_en),
    .done  (quiet_done)
  );

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      st <= JAB_OFF;
    end else if (st == JAB_ON) begin
      if (quiet_done) st <= JAB_OFF;
    end else if (trip) begin
      st <= JAB_ON;
    end
  end

  jab_status u_stat (
    .clk      (clk),
    .rst      (rst),
    .set      (trip),
    .jab_live (st == JAB_ON),
    .rd_stb   (rd_stb),
    .sticky   (stat_jab)
  );

  assign tx_force_idle = (st == JAB_ON);
  assign mac_col       = (st == JAB_ON);
  assign chan_jab      = (st == JAB_ON);
endmodule

// File: rtl/jab_wdog_chk.sv
`timescale 1ns/1ps
module jab_wdog_chk (
  input logic clk,
  input logic rst,
  input logic tx_en,
  input logic speed_100,
  input logic jab_dis,
  input logic rd_stb,
  input logic tx_force_idle,
  input logic mac_col,
  input logic chan_jab,
  input logic stat_jab
);
  a_r4_fast_no_jab: assert property (@(posedge clk) disable iff (rst)
    speed_100 |=> !tx_force_idle);
  a_r5_dis_no_jab: assert property (@(posedge clk) disable iff (rst)
    jab_dis |=> !chan_jab);
  a_r2_trip_needs_tx: assert property (@(posedge clk) disable iff (rst)
    $rose(mac_col) |-> $past(tx_en));
  a_r8_set_on_trip: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_force_idle) |-> stat_jab);
  a_r8_sticky_hold: assert property (@(posedge clk) disable iff (rst)
    (stat_jab && !rd_stb) |=> stat_jab);
  a_r7_release_quiet: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_force_idle) |-> ($past(!tx_en) || $past(speed_100) || $past(jab_dis)));
endmodule

bind jab_wdog jab_wdog_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .tx_en         (tx_en),
  .speed_100     (speed_100),
  .jab_dis       (jab_dis),
  .rd_stb        (rd_stb),
  .tx_force_idle (tx_force_idle),
  .mac_col       (mac_col),
  .chan_jab      (chan_jab),
  .stat_jab      (stat_jab)
);

// File: tb/sim_jab_wdog.sv
`timescale 1ns/1ps
module sim_jab_wdog;
  localparam int LIM_W = 20;
  localparam int UNJAB = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_en = 1'b0, speed_100 = 1'b0, jab_dis = 1'b0, rd_stb = 1'b0;
  logic [LIM_W-1:0] limit = 20'd5;
  logic tx_force_idle, mac_col, chan_jab, stat_jab;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [3:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  jab_wdog #(.UNJAB_CYC(UNJAB), .LIM_W(LIM_W)) u0 (
    .clk(clk), .rst(rst), .tx_en(tx_en), .speed_100(speed_100),
    .jab_dis(jab_dis), .limit(limit), .rd_stb(rd_stb),
    .tx_force_idle(tx_force_idle), .mac_col(mac_col),
    .chan_jab(chan_jab), .stat_jab(stat_jab)
  );

  // Monitor: compare one expected item per cycle, away from the active edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [3:0] e, a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {tx_force_idle, mac_col, chan_jab, stat_jab};
      checks++;
      if (a !== e) begin
        errors++;
        $display("FAIL %s: {idle,col,chan,stat} got %b expected %b", t, a, e);
      end
    end
  end

  // Driver: apply inputs at negedge, push the expectation after the edge
  task automatic cyc(input logic t, input logic s, input logic d, input logic r,
                     input logic [3:0] e, input string tag);
    @(negedge clk);
    tx_en = t; speed_100 = s; jab_dis = d; rd_stb = r;
    @(posedge clk);
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic run(input int n, input logic t, input logic s, input logic d,
                     input logic [3:0] e, input string tag);
    for (int i = 0; i < n; i++) cyc(t, s, d, 1'b0, e, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    cyc(0, 0, 0, 0, 4'b0000, "R1 reset state");

    // R2: exactly limit cycles, no trip
    run(5, 1, 0, 0, 4'b0000, "R2 burst at limit");
    cyc(0, 0, 0, 0, 4'b0000, "R2 after burst at limit");

    // R6: one low cycle restarts the count
    run(4, 1, 0, 0, 4'b0000, "R6 first part");
    cyc(0, 0, 0, 0, 4'b0000, "R6 gap");
    run(4, 1, 0, 0, 4'b0000, "R6 second part");
    cyc(0, 0, 0, 0, 4'b0000, "R6 end");

    // R2/R3/R7/R8: trip, hold, quiet restart, release, clear
    run(5, 1, 0, 0, 4'b0000, "R2 before trip");
    cyc(1, 0, 0, 1, 4'b1111, "R8 trip with read strobe");
    run(3, 1, 0, 0, 4'b1111, "R3 held while tx high");
    run(3, 0, 0, 0, 4'b1111, "R7 quiet part 1");
    cyc(0, 0, 0, 1, 4'b1111, "R8 read during jabber");
    run(3, 0, 0, 0, 4'b1111, "R7 quiet part 2");
    cyc(1, 0, 0, 0, 4'b1111, "R7 quiet broken");
    run(7, 0, 0, 0, 4'b1111, "R7 quiet restarted");
    cyc(0, 0, 0, 0, 4'b0001, "R7 release on last quiet cycle");
    cyc(0, 0, 0, 0, 4'b0001, "R8 sticky after release");
    cyc(0, 0, 0, 1, 4'b0000, "R8 cleared by read");

    // R4: 100 Mbps
    run(12, 1, 1, 0, 4'b0000, "R4 long burst at 100M");
    cyc(0, 0, 0, 0, 4'b0000, "R4 back to 10M");
    run(5, 1, 0, 0, 4'b0000, "R4 burst before trip");
    cyc(1, 0, 0, 0, 4'b1111, "R4 trip at 10M");
    cyc(1, 1, 0, 0, 4'b0001, "R4 switch to 100M ends jabber");
    cyc(0, 1, 0, 1, 4'b0000, "R8 clear at 100M");
    cyc(0, 0, 0, 0, 4'b0000, "R4 idle");

    // R5: disable
    run(10, 1, 0, 1, 4'b0000, "R5 long burst disabled");
    cyc(0, 0, 0, 0, 4'b0000, "R5 enable");
    run(5, 1, 0, 0, 4'b0000, "R5 burst before trip");
    cyc(1, 0, 0, 0, 4'b1111, "R5 trip");
    cyc(1, 0, 1, 0, 4'b0001, "R5 disable ends jabber");
    cyc(0, 0, 0, 1, 4'b0000, "R5 clear");

    // R9: programmed limit of 2
    @(negedge clk) limit = 20'd2;
    run(2, 1, 0, 0, 4'b0000, "R9 two cycles");
    cyc(1, 0, 0, 0, 4'b1111, "R9 trip at third");
    run(7, 0, 0, 0, 4'b1111, "R9 quiet");
    cyc(0, 0, 0, 0, 4'b0001, "R9 release");
    cyc(0, 0, 0, 1, 4'b0000, "R9 clear");

    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 5000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule